// File: doc/BRIEF.md
# Interrupt-capable 32-pin GPIO port

This block is one 32-pin general-purpose I/O port sitting behind a plain 32-bit register bus. Software writes an output value and a per-pin output-enable mask, and reads back the pin levels. Every pin can also raise an interrupt. It can be armed on a low level, a high level, a rising edge or a falling edge.

Pin inputs cross into the clock domain through a two-stage synchroniser before any trigger logic sees them. A pending bit is latched per pin whether or not that pin is enabled. Software clears pending bits by writing ones. The enabled pending bits drive three request lines: one for pins 0 to 15, one for pins 16 to 31, and one that ORs both halves.

Register offsets are parameters. The read path is combinational on the address, and writes take effect at the clock edge where `bus_sel` and `bus_wr` are both high.

Top module: `gpio_irq_port`

## Requirements
- R1: While `rst` is high and after it is released, the output, direction, mask, both trigger-configuration and pending registers read 0. `pad_oe` is 0 and all three interrupt outputs are low.
- R2: A write to the output register (default offset 0x00) appears on `pad_out`. A write to the direction register (0x04) appears on `pad_oe`, where a 1 enables the pin driver. Both registers read back the value written.
- R3: The pin-level register (0x08) returns `pad_in` as sampled by two flops, whatever the direction bits hold. Writes to it change no register.
- R4: Pin p has a 2-bit trigger field at bits [2*(p mod 16)+1 : 2*(p mod 16)]. Pins 0 to 15 use the lower configuration register (0x10) and pins 16 to 31 use the upper one (0x14); address bit 2 tells the two apart. The encodings are 00 low level, 01 high level, 10 rising edge and 11 falling edge.
- R5: In a level mode the pending bit is set on every clock while the synchronised pin holds the active level, so a clear has no lasting effect. The bit is first visible three clock edges after the pin change: two synchroniser edges, then the latch edge.
- R6: In an edge mode, one synchronised transition in the chosen direction sets the pending bit once, with the same three-edge latency. After it is cleared, the bit stays clear.
- R7: Writing the pending register (0x1C) clears each bit where the write data holds a 1 and leaves the others unchanged.
- R8: Pending bits latch regardless of the mask register (0x18). `irq_lo` is the OR of pending AND mask over pins 0 to 15, `irq_hi` is the same over pins 16 to 31, and `irq_any` is their OR.
- R9: When a clear write and a new event for the same pin fall on the same clock edge, the pending bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier for the access |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on `bus_addr` |
| pad_in | input | 32 | Pin levels from the pads |
| pad_out | output | 32 | Output value for the pads |
| pad_oe | output | 32 | Per-pin output enable |
| irq_lo | output | 1 | Request for pins 0 to 15 |
| irq_hi | output | 1 | Request for pins 16 to 31 |
| irq_any | output | 1 | OR of both request lines |

## Verification
A trigger field decoded at the wrong bit position, or taken from the wrong configuration register, makes a different pin latch. A wrong encoding makes the pin latch on the wrong condition. Either fault shows in the pending register exactly three clock edges after the pin moves. A synchroniser with a missing or extra stage moves that moment by one edge, so the bench checks the edge before it as well as the edge itself. A clear that wins over a simultaneous event, or a level trigger that latches only once, leaves the pending bit clear on the next read instead of set. A request line mapped to the wrong half shows at once on `irq_lo` and `irq_hi` after a single-pin mask is written.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int NPINS  = 32;
    localparam int HALF   = NPINS / 2;
    localparam int TRIG_W = 2;

    typedef enum logic [TRIG_W-1:0] {
        TRIG_LOW  = 2'b00,
        TRIG_HIGH = 2'b01,
        TRIG_RISE = 2'b10,
        TRIG_FALL = 2'b11
    } trig_e;

    typedef struct packed {
        logic [NPINS-1:0] dout;
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] mask;
        logic [NPINS-1:0] cfg_lo;
        logic [NPINS-1:0] cfg_hi;
    } port_regs_t;

    // Trigger field of one pin: the pin's half picks the register,
    // pin mod HALF picks the 2-bit slot inside it.
    function automatic trig_e pin_trig(input logic [NPINS-1:0] lo,
                                       input logic [NPINS-1:0] hi,
                                       input int               pin);
        logic [NPINS-1:0] word;
        word = (pin >= HALF) ? hi : lo;
        return trig_e'(word[TRIG_W*(pin % HALF) +: TRIG_W]);
    endfunction

    // Decides whether a pin produces an event this cycle.
    function automatic logic trig_hit(input trig_e t, input logic cur, input logic prev);
        case (t)
            TRIG_LOW:  return ~cur;
            TRIG_HIGH: return cur;
            TRIG_RISE: return cur & ~prev;
            default:   return ~cur & prev;
        endcase
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_async;
            sync_q <= meta_q;
        end
    end

    assign d_sync = sync_q;
endmodule

// File: rtl/gpio_event_det.sv
module gpio_event_det
    import gpio_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] pin_lvl,
    input  logic [NPINS-1:0] cfg_lo,
    input  logic [NPINS-1:0] cfg_hi,
    output logic [NPINS-1:0] evt
);
    logic [NPINS-1:0] prev_q;
    logic [NPINS-1:0] edge_cfg;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= pin_lvl;
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        trig_e mode;
        assign mode        = pin_trig(cfg_lo, cfg_hi, i);
        assign evt[i]      = trig_hit(mode, pin_lvl[i], prev_q[i]);
        assign edge_cfg[i] = mode[1];
    end

    // An edge-armed pin cannot fire on two consecutive cycles while its setup holds
    p_edge_one_shot_r6: assert property (@(posedge clk) disable iff (rst)
        ($stable(cfg_lo) && $stable(cfg_hi)) |-> ((evt & $past(evt) & edge_cfg) == '0));
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status
    import gpio_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] evt,
    input  logic [NPINS-1:0] clr,
    input  logic [NPINS-1:0] mask,
    output logic [NPINS-1:0] pend,
    output logic             irq_lo,
    output logic             irq_hi,
    output logic             irq_any
);
    logic [NPINS-1:0] pend_q;
    logic [NPINS-1:0] live;

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= (pend_q & ~clr) | evt;
    end

    assign pend    = pend_q;
    assign live    = pend_q & mask;
    assign irq_lo  = |live[HALF-1:0];
    assign irq_hi  = |live[NPINS-1:HALF];
    assign irq_any = |live;

    // An event always lands, even against a clear in the same cycle
    p_event_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (evt != '0) |=> ((pend & $past(evt)) == $past(evt)));

    // Cleared bits without a new event drop
    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (clr != '0) |=> ((pend & $past(clr & ~evt)) == '0));

    // Without a clear nothing pending is lost
    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (clr == '0) |=> ((pend & $past(pend)) == $past(pend)));
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DOUT_OFS = 'h00,
    parameter int DIR_OFS  = 'h04,
    parameter int PAD_OFS  = 'h08,
    parameter int CFG_OFS  = 'h10,
    parameter int MASK_OFS = 'h18,
    parameter int PEND_OFS = 'h1C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [31:0]       pad_in,
    output logic [31:0]       pad_out,
    output logic [31:0]       pad_oe,
    output logic              irq_lo,
    output logic              irq_hi,
    output logic              irq_any
);
    localparam logic [ADDR_W-1:0] A_DOUT  = ADDR_W'(DOUT_OFS);
    localparam logic [ADDR_W-1:0] A_DIR   = ADDR_W'(DIR_OFS);
    localparam logic [ADDR_W-1:0] A_PAD   = ADDR_W'(PAD_OFS);
    localparam logic [ADDR_W-1:0] A_CFGLO = ADDR_W'(CFG_OFS);
    localparam logic [ADDR_W-1:0] A_CFGHI = ADDR_W'(CFG_OFS + 4);
    localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(MASK_OFS);
    localparam logic [ADDR_W-1:0] A_PEND  = ADDR_W'(PEND_OFS);

    port_regs_t       regs_q;
    logic             wr_en;
    logic [NPINS-1:0] pin_lvl;
    logic [NPINS-1:0] evt;
    logic [NPINS-1:0] clr;
    logic [NPINS-1:0] pend;

    assign wr_en = bus_sel & bus_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else if (wr_en) begin
            case (bus_addr)
                A_DOUT:  regs_q.dout   <= bus_wdata;
                A_DIR:   regs_q.dir    <= bus_wdata;
                A_CFGLO: regs_q.cfg_lo <= bus_wdata;
                A_CFGHI: regs_q.cfg_hi <= bus_wdata;
                A_MASK:  regs_q.mask   <= bus_wdata;
                default: ;
            endcase
        end
    end

    assign clr = (wr_en && bus_addr == A_PEND) ? bus_wdata : '0;

    always_comb begin
        case (bus_addr)
            A_DOUT:  bus_rdata = regs_q.dout;
            A_DIR:   bus_rdata = regs_q.dir;
            A_PAD:   bus_rdata = pin_lvl;
            A_CFGLO: bus_rdata = regs_q.cfg_lo;
            A_CFGHI: bus_rdata = regs_q.cfg_hi;
            A_MASK:  bus_rdata = regs_q.mask;
            A_PEND:  bus_rdata = pend;
            default: bus_rdata = '0;
        endcase
    end

    assign pad_out = regs_q.dout;
    assign pad_oe  = regs_q.dir;

    gpio_sync #(.W(NPINS)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (pad_in),
        .d_sync  (pin_lvl)
    );

    gpio_event_det u_det (
        .clk     (clk),
        .rst     (rst),
        .pin_lvl (pin_lvl),
        .cfg_lo  (regs_q.cfg_lo),
        .cfg_hi  (regs_q.cfg_hi),
        .evt     (evt)
    );

    gpio_irq_status u_stat (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .clr     (clr),
        .mask    (regs_q.mask),
        .pend    (pend),
        .irq_lo  (irq_lo),
        .irq_hi  (irq_hi),
        .irq_any (irq_any)
    );

    // With every pin masked no request line may be high
    p_masked_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (regs_q.mask == '0) |-> (!irq_lo && !irq_hi && !irq_any));

    // The combined line never disagrees with the two half lines
    p_any_matches_r8: assert property (@(posedge clk) disable iff (rst)
        irq_any == (irq_lo | irq_hi));
endmodule

// File: tb/tb_gpio_irq_port.sv
module tb_gpio_irq_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic        irq_lo;
    logic        irq_hi;
    logic        irq_any;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    localparam logic [7:0] R_DOUT = 8'h00, R_DIR = 8'h04, R_PAD = 8'h08,
                           R_CLO = 8'h10, R_CHI = 8'h14, R_MASK = 8'h18, R_PEND = 8'h1C;

    always #10 clk = ~clk;

    gpio_irq_port dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .irq_lo(irq_lo), .irq_hi(irq_hi), .irq_any(irq_any)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_neg(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    function automatic logic [2:0] exp_irq(input int pin, input logic on);
        if (!on) return 3'b000;
        return (pin < 16) ? 3'b101 : 3'b011;
    endfunction

    // One pin, one trigger mode; every other pin is rising-edge armed and held low
    task automatic run_pin(input int pin, input logic [1:0] mode);
        logic [31:0] v, cfg, idle, act;
        logic        lvl, idle_lvl;
        lvl      = (mode == 2'b00 || mode == 2'b10) ? 1'b0 : 1'b1;
        lvl      = ~lvl; // active level: low->0? recomputed below
        case (mode)
            2'b00: begin idle_lvl = 1'b1; lvl = 1'b0; end
            2'b01: begin idle_lvl = 1'b0; lvl = 1'b1; end
            2'b10: begin idle_lvl = 1'b0; lvl = 1'b1; end
            default: begin idle_lvl = 1'b1; lvl = 1'b0; end
        endcase
        cfg = 32'hAAAA_AAAA;
        cfg[2*(pin % 16) +: 2] = mode;
        wr(R_CLO, (pin < 16) ? cfg : 32'hAAAA_AAAA);
        wr(R_CHI, (pin < 16) ? 32'hAAAA_AAAA : cfg);
        wr(R_MASK, 32'h0);
        idle = 32'h0; idle[pin] = idle_lvl;
        act  = idle;  act[pin]  = lvl;
        pad_in = idle;
        wait_neg(4);
        wr(R_PEND, 32'hFFFF_FFFF);
        rd(R_PEND, v); chk("R7 clear all", v, 32'h0);
        wr(R_MASK, 32'h1 << pin);
        chk("R8 idle quiet", {29'h0, irq_lo, irq_hi, irq_any}, 32'h0);
        pad_in = act;
        @(negedge clk);
        @(negedge clk);
        rd(R_PEND, v); chk("R5/R6 latency not yet", v, 32'h0);
        @(negedge clk);
        rd(R_PEND, v); chk(mode[1] ? "R6 edge latch" : "R5 level latch", v, 32'h1 << pin);
        chk("R8 request lines", {29'h0, irq_lo, irq_hi, irq_any}, {29'h0, exp_irq(pin, 1'b1)});
        wr(R_PEND, 32'h1 << pin);
        rd(R_PEND, v);
        chk(mode[1] ? "R6 edge cleared" : "R5 level re-set", v, mode[1] ? 32'h0 : (32'h1 << pin));
        wr(R_MASK, 32'h0);
        rd(R_PEND, v);
        chk("R8 pending ignores mask", v, mode[1] ? 32'h0 : (32'h1 << pin));
        chk("R8 masked lines low", {29'h0, irq_lo, irq_hi, irq_any}, 32'h0);
        pad_in = idle;
        wait_neg(4);
        wr(R_PEND, 32'hFFFF_FFFF);
    endtask

    initial begin
        logic [31:0] v;
        // R1 reset values, observed during reset
        wait_neg(3);
        rd(R_DOUT, v); chk("R1 data reset", v, 32'h0);
        rd(R_DIR,  v); chk("R1 dir reset", v, 32'h0);
        rd(R_CLO,  v); chk("R1 cfg lo reset", v, 32'h0);
        rd(R_CHI,  v); chk("R1 cfg hi reset", v, 32'h0);
        rd(R_MASK, v); chk("R1 mask reset", v, 32'h0);
        rd(R_PEND, v); chk("R1 pending reset", v, 32'h0);
        chk("R1 oe reset", pad_oe, 32'h0);
        chk("R1 irq reset", {29'h0, irq_lo, irq_hi, irq_any}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        // R1: default low-level triggers with pads low latch but stay masked
        chk("R1 irq masked after reset", {29'h0, irq_lo, irq_hi, irq_any}, 32'h0);

        // R2 output and direction registers
        wr(R_DOUT, 32'hA5C3_0F1E);
        wr(R_DIR,  32'h00FF_F00F);
        chk("R2 pad_out", pad_out, 32'hA5C3_0F1E);
        chk("R2 pad_oe", pad_oe, 32'h00FF_F00F);
        rd(R_DOUT, v); chk("R2 data readback", v, 32'hA5C3_0F1E);
        rd(R_DIR,  v); chk("R2 dir readback", v, 32'h00FF_F00F);

        // R3 pin levels follow pad_in regardless of direction; writes ignored
        pad_in = 32'h1234_8765;
        wait_neg(2);
        rd(R_PAD, v); chk("R3 pad level", v, 32'h1234_8765);
        wr(R_PAD, 32'hFFFF_FFFF);
        rd(R_PAD, v);  chk("R3 pad write ignored", v, 32'h1234_8765);
        rd(R_DOUT, v); chk("R3 data untouched", v, 32'hA5C3_0F1E);
        rd(R_DIR,  v); chk("R3 dir untouched", v, 32'h00FF_F00F);
        wr(R_DIR, 32'h0);
        pad_in = 32'h0;

        // R4 configuration registers are separate and read back
        wr(R_CLO, 32'h1B1B_1B1B);
        wr(R_CHI, 32'hE4E4_E4E4);
        rd(R_CLO, v); chk("R4 cfg lo readback", v, 32'h1B1B_1B1B);
        rd(R_CHI, v); chk("R4 cfg hi readback", v, 32'hE4E4_E4E4);

        // R4/R5/R6/R8 sweep over every pin and every trigger encoding
        for (int p = 0; p < 32; p++)
            for (int m = 0; m < 4; m++)
                run_pin(p, 2'(m));

        // R7 partial clear leaves other bits alone (pins 3 and 20 rising)
        wr(R_CLO, 32'hAAAA_AAAA);
        wr(R_CHI, 32'hAAAA_AAAA);
        pad_in = 32'h0;
        wait_neg(4);
        wr(R_PEND, 32'hFFFF_FFFF);
        pad_in = 32'h0010_0008;
        wait_neg(3);
        wr(R_PEND, 32'h0000_0008);
        rd(R_PEND, v); chk("R7 partial clear", v, 32'h0010_0000);
        wr(R_PEND, 32'h0);
        rd(R_PEND, v); chk("R7 zero write keeps", v, 32'h0010_0000);

        // R9 clear and event on the same edge: pin 5 rising
        wr(R_PEND, 32'hFFFF_FFFF);
        pad_in = 32'h0;
        wait_neg(4);
        wr(R_PEND, 32'hFFFF_FFFF);
        pad_in = 32'h0000_0020;
        @(negedge clk);
        @(negedge clk);
        // write committed on the third edge, same edge as the latch
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = R_PEND; bus_wdata = 32'h0000_0020;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        rd(R_PEND, v); chk("R9 event beats clear", v, 32'h0000_0020);

        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule